// File: doc/BRIEF.md
# Hop-Count Adaptive Route Selector

This block is the route stage at one input of a five-port mesh router whose ports are local, north, south, east and west. The flit that opens a packet already carries what routing needs: a two-bit quadrant code and the number of hops still to go on each axis. The stage does no address arithmetic. It reads the code and the hop counts, looks at the free virtual-channel counts reported by the four neighbours, and picks one output port. It then emits the head flit with the hop count for the axis it used reduced by one.

The chosen port is held for the rest of the packet. Body and tail flits leave on that port without change, and the hold is dropped once the tail has gone out. Every flit appears at the output one clock after it is accepted. The output carries a one-hot port vector next to the flit.

Top module: `hop_route_sel`

## Requirements
- R1: While reset is asserted and after it is released with no input, `out_valid` is 0 and `out_port` is all zeros.
- R2: Flit bits [1:0] give the kind: 00 body, 01 head, 10 tail, 11 single-flit packet (head and tail at once). Bit 2 is the Y direction (0 north, 1 south). Bit 3 is the X direction (0 east, 1 west). X hops sit at bits [4 +: HOP_W] and Y hops sit at the next HOP_W bits. `out_port` bit 0 is local, bit 1 north, bit 2 south, bit 3 east and bit 4 west. A head whose two hop counts are both zero goes to local with its hop fields unchanged.
- R3: A head with zero X hops and nonzero Y hops goes north when the Y direction bit is 0 and south when it is 1. Its Y hops leave reduced by one.
- R4: A head with zero Y hops and nonzero X hops goes east when the X direction bit is 0 and west when it is 1. Its X hops leave reduced by one.
- R5: When both hop counts are nonzero, the code {X dir, Y dir} selects a pair of ports: 00 east or north, 10 north or west, 11 west or south, 01 south or east. The port taken is always one of that pair, and its axis hop count is reduced by one.
- R6: Within a pair, the first-named port is taken only if its free-VC count is strictly greater than the other port's count. Equal counts go to the second-named port.
- R7: On a head, the kind bits, the direction bits, the hop field of the unused axis and all payload bits leave unchanged.
- R8: `out_valid` equals `in_valid` delayed by exactly one clock, and each output flit belongs to the input accepted one clock earlier.
- R9: Body and tail flits leave on the port chosen for their head, with every bit unchanged.
- R10: After a tail or a single-flit packet has gone out, a body flit with no open packet leaves with an all-zero port vector.
- R11: While `out_valid` is 0, `out_port` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Flit present at the input this cycle |
| in_flit | input | FLIT_W | Incoming flit |
| free_n | input | CNT_W | Free VCs at the north neighbour |
| free_s | input | CNT_W | Free VCs at the south neighbour |
| free_e | input | CNT_W | Free VCs at the east neighbour |
| free_w | input | CNT_W | Free VCs at the west neighbour |
| out_valid | output | 1 | Flit present at the output |
| out_port | output | 5 | One-hot chosen port: local, N, S, E, W from bit 0 |
| out_flit | output | FLIT_W | Outgoing flit with updated hop field on heads |

## Verification
The bench builds the block with a 32-bit flit, 3-bit hop fields and 3-bit free counts. This allows hop counts of up to seven, so a head can be sent several hops out, and it also allows the all-zero hop case and the counts of one that reach zero. Free counts cover 0 to 4, which reaches equal counts in every quadrant, so all four tie outcomes are checked. A random stream of mixed flit kinds, including bodies with no packet open and heads that arrive while a packet is still open, is compared cycle by cycle against a behavioural model.

// File: rtl/hop_route_sel.sv
module hop_route_sel #(
  parameter int FLIT_W = 64,
  parameter int HOP_W  = 3,
  parameter int CNT_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [FLIT_W-1:0] in_flit,
  input  logic [CNT_W-1:0]  free_n,
  input  logic [CNT_W-1:0]  free_s,
  input  logic [CNT_W-1:0]  free_e,
  input  logic [CNT_W-1:0]  free_w,
  output logic              out_valid,
  output logic [4:0]        out_port,
  output logic [FLIT_W-1:0] out_flit
);
  localparam int XH_LO = 4;
  localparam int YH_LO = XH_LO + HOP_W;
  localparam logic [4:0] P_L = 5'b00001, P_N = 5'b00010, P_S = 5'b00100,
                         P_E = 5'b01000, P_W = 5'b10000;

  logic             is_head, is_tail, rd_x, rd_y;
  logic [HOP_W-1:0] xh, yh;
  logic [4:0]       pick, held;
  logic [FLIT_W-1:0] hdr_next;

  assign is_head = in_flit[0];
  assign is_tail = in_flit[1];
  assign rd_y    = in_flit[2];
  assign rd_x    = in_flit[3];
  assign xh      = in_flit[XH_LO +: HOP_W];
  assign yh      = in_flit[YH_LO +: HOP_W];

  always_comb begin
    if (xh == '0 && yh == '0)      pick = P_L;
    else if (xh == '0)             pick = rd_y ? P_S : P_N;
    else if (yh == '0)             pick = rd_x ? P_W : P_E;
    else begin
      unique case ({rd_x, rd_y})
        2'b00:   pick = (free_e > free_n) ? P_E : P_N;
        2'b10:   pick = (free_n > free_w) ? P_N : P_W;
        2'b11:   pick = (free_w > free_s) ? P_W : P_S;
        default: pick = (free_s > free_e) ? P_S : P_E;
      endcase
    end
  end

  always_comb begin
    hdr_next = in_flit;
    if (pick[3] || pick[4]) hdr_next[XH_LO +: HOP_W] = xh - HOP_W'(1);
    if (pick[1] || pick[2]) hdr_next[YH_LO +: HOP_W] = yh - HOP_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_port  <= '0;
      out_flit  <= '0;
      held      <= '0;
    end else begin
      out_valid <= in_valid;
      out_port  <= '0;
      if (in_valid) begin
        if (is_head) begin
          out_port <= pick;
          out_flit <= hdr_next;
          held     <= is_tail ? 5'b0 : pick;
        end else begin
          out_port <= held;
          out_flit <= in_flit;
          if (is_tail) held <= '0;
        end
      end
    end
  end

  AST_IDLE_NO_PORT: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> out_port == 5'b0); // R11
  AST_PORT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(out_port)); // R2
  AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> out_valid == $past(in_valid)); // R8
  AST_DIR_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_flit[0] |-> out_flit[3:0] == $past(in_flit[3:0])); // R7
  AST_LOCAL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_flit[0] && out_port[0] |->
      out_flit[XH_LO +: 2*HOP_W] == '0); // R2
  AST_X_DEC: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_flit[0] && (out_port[3] || out_port[4]) |->
      out_flit[XH_LO +: HOP_W] == $past(in_flit[XH_LO +: HOP_W]) - HOP_W'(1)); // R4
  AST_Y_DEC: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_flit[0] && (out_port[1] || out_port[2]) |->
      out_flit[YH_LO +: HOP_W] == $past(in_flit[YH_LO +: HOP_W]) - HOP_W'(1)); // R3
  AST_BODY_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_flit[0] && $past(out_valid && out_flit[0] && !out_flit[1]) |->
      out_port == $past(out_port)); // R9
endmodule

// File: tb/sim_hop_route_sel.sv
module sim_hop_route_sel;
  localparam int FW = 32, HW = 3, CW = 3;

  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0;
  logic [FW-1:0] in_flit = '0;
  logic [CW-1:0] free_n = '0, free_s = '0, free_e = '0, free_w = '0;
  logic out_valid;
  logic [4:0] out_port;
  logic [FW-1:0] out_flit;

  int checks = 0, errors = 0, cyc = 0;
  int m_lock = -1;
  bit e_valid;
  logic [4:0] e_port;
  logic [FW-1:0] e_flit;

  always #5 clk = ~clk;

  hop_route_sel #(.FLIT_W(FW), .HOP_W(HW), .CNT_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_flit(in_flit),
    .free_n(free_n), .free_s(free_s), .free_e(free_e), .free_w(free_w),
    .out_valid(out_valid), .out_port(out_port), .out_flit(out_flit));

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  function automatic logic [FW-1:0] mk(int kind, int rx, int ry, int xh, int yh, int pay);
    logic [FW-1:0] f;
    f = '0;
    f[1:0] = kind[1:0];
    f[2] = ry[0];
    f[3] = rx[0];
    f[4 +: HW] = xh[HW-1:0];
    f[4+HW +: HW] = yh[HW-1:0];
    f[FW-1:4+2*HW] = pay[FW-5-2*HW:0];
    return f;
  endfunction

  // behavioural model: port index 0 L,1 N,2 S,3 E,4 W
  task automatic model();
    int kind, rx, ry, xh, yh, idx, first, second, xc, yc;
    int fr[5];
    fr[0] = 0; fr[1] = free_n; fr[2] = free_s; fr[3] = free_e; fr[4] = free_w;
    e_valid = in_valid;
    e_port = '0;
    if (!in_valid) return;
    kind = in_flit[1:0]; ry = in_flit[2]; rx = in_flit[3];
    xh = in_flit[4 +: HW]; yh = in_flit[4+HW +: HW];
    e_flit = in_flit;
    if (kind == 1 || kind == 3) begin
      xc = rx ? 4 : 3; yc = ry ? 2 : 1;
      if (xh == 0 && yh == 0) idx = 0;
      else if (xh == 0) idx = yc;
      else if (yh == 0) idx = xc;
      else begin
        first = (rx == ry) ? xc : yc;
        second = (first == xc) ? yc : xc;
        idx = (fr[first] > fr[second]) ? first : second;
      end
      if (idx >= 3) e_flit[4 +: HW] = HW'(xh - 1);
      else if (idx >= 1) e_flit[4+HW +: HW] = HW'(yh - 1);
      e_port = 5'(1 << idx);
      m_lock = (kind == 3) ? -1 : idx;
    end else begin
      e_port = (m_lock < 0) ? 5'b0 : 5'(1 << m_lock);
      if (kind == 2) m_lock = -1;
    end
  endtask

  task automatic check(string tag);
    checks++;
    if (out_valid !== e_valid || out_port !== e_port ||
        (e_valid && out_flit !== e_flit)) begin
      errors++;
      $display("FAIL %s: actual v=%0b port=%b flit=%h expected v=%0b port=%b flit=%h",
               tag, out_valid, out_port, out_flit, e_valid, e_port, e_flit);
    end
  endtask

  task automatic step(bit v, logic [FW-1:0] f, string tag);
    in_valid = v; in_flit = f;
    model();
    @(posedge clk);
    @(negedge clk);
    check(tag);
  endtask

  task automatic frees(int n, int s, int e, int w);
    free_n = CW'(n); free_s = CW'(s); free_e = CW'(e); free_w = CW'(w);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    e_valid = 0; e_port = '0;
    check("R1 in reset");
    rst_n = 1'b1;
    step(0, '0, "R1 after reset");
    frees(1, 1, 1, 1);
    step(1, mk(3, 0, 0, 0, 0, 77), "R2 local");
    step(1, mk(3, 0, 0, 0, 3, 5), "R3 north");
    step(1, mk(3, 1, 1, 0, 1, 6), "R3 south to zero");
    step(1, mk(3, 0, 1, 2, 0, 7), "R4 east");
    step(1, mk(3, 1, 0, 7, 0, 8), "R4 west");
    frees(0, 0, 4, 0); step(1, mk(3, 0, 0, 2, 2, 9), "R5 q00 east wins");
    frees(2, 0, 2, 0); step(1, mk(3, 0, 0, 2, 2, 9), "R6 q00 tie north");
    frees(3, 0, 0, 1); step(1, mk(3, 1, 0, 1, 1, 10), "R5 q10 north wins");
    frees(3, 0, 0, 3); step(1, mk(3, 1, 0, 1, 1, 10), "R6 q10 tie west");
    frees(0, 1, 0, 2); step(1, mk(3, 1, 1, 3, 4, 11), "R5 q11 west wins");
    frees(0, 4, 0, 4); step(1, mk(3, 1, 1, 3, 4, 11), "R6 q11 tie south");
    frees(0, 4, 3, 0); step(1, mk(3, 0, 1, 5, 6, 12), "R5 q01 south wins");
    frees(0, 0, 0, 0); step(1, mk(3, 0, 1, 5, 6, 12), "R6 q01 tie east");
    step(0, '0, "R11 idle");
    frees(2, 0, 1, 0);
    step(1, mk(1, 0, 0, 3, 3, 300), "R7 head");
    frees(0, 0, 4, 0);
    step(1, mk(0, 1, 1, 5, 5, 301), "R9 body follows");
    step(0, '0, "R8 bubble");
    step(1, mk(0, 0, 1, 0, 0, 302), "R9 body after bubble");
    step(1, mk(2, 1, 0, 1, 0, 303), "R9 tail");
    step(1, mk(0, 0, 0, 1, 1, 304), "R10 body after tail");
    step(1, mk(3, 1, 0, 1, 0, 305), "R10 single");
    step(1, mk(0, 0, 0, 0, 0, 306), "R10 body after single");
    for (int i = 0; i < 400; i++) begin
      frees($urandom_range(0, 4), $urandom_range(0, 4), $urandom_range(0, 4), $urandom_range(0, 4));
      step($urandom_range(0, 3) != 0,
           mk($urandom_range(0, 3), $urandom_range(0, 1), $urandom_range(0, 1),
              $urandom_range(0, 7), $urandom_range(0, 7), $urandom),
           "R5 R8 R9 random");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule